// File: doc/BRIEF.md
# Packet Arrival and Content-Change Status Registers

This block keeps two small status registers for a link receiver that sorts incoming packets into seven kinds. The first, the arrival register, gets a bit set the first time a packet of a given kind is reported. That bit stays set until reset, or until a loss-of-clock pulse arrives. The second, the change register, gets a bit set whenever a packet of that kind arrives with content that differs from the last one. Both registers are sticky: once a bit is set, only the events listed below clear it.

A byte-wide read/write port gives access to both registers. The arrival register is at one fixed address. The change register is mirrored at every address in the upper half of the map whose three low bits are all ones. A read at any of those mirrors returns the flags and clears all of them in the same cycle. That lets software poll for changes without a separate acknowledge write.

Top module: `pkt_status_regs`

## Requirements
- R1: After reset, both registers hold 0x00 and `reg_rdata` is 0x00.
- R2: Packet kind code k (0 AVI, 1 audio, 2 source-product description, 3 MPEG source, 4 content protection, 5 ISRC part 1, 6 ISRC part 2) maps to bit k of both registers. Bit 7 always reads 0. Code 7 has no effect.
- R3: An arrival bit, once set, stays set until reset or a `clk_lost` pulse.
- R4: A `clk_lost` pulse clears the arrival register but leaves the change register untouched. A packet reported in the same cycle as the pulse leaves its own arrival bit set.
- R5: A packet with `pkt_changed` high sets both its arrival bit and its change bit. A packet with `pkt_changed` low sets only its arrival bit.
- R6: A read at address 0x5A returns the arrival register. Read data appears on `reg_rdata` in the cycle after `reg_rd`, and is 0x00 in any cycle that follows no read.
- R7: Every address with bit 7 = 1 and bits [2:0] = 111 (0x87, 0x8F, ..., 0xFF) returns the same change register value.
- R8: A read at any change-register mirror clears all change flags. A read of the arrival register clears nothing.
- R9: When a change event coincides with a clearing read, the read returns the value from before that cycle, and the new event's bit is set afterwards.
- R10: Writes at any address leave both registers unchanged.
- R11: A read at any other address (for example 0x07 or 0x88) returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | One-cycle strobe: a packet was received |
| pkt_type | input | 3 | Packet kind code |
| pkt_changed | input | 1 | The packet content differs from the previous one of this kind |
| clk_lost | input | 1 | One-cycle pulse: link clock lost |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data (has no effect) |
| reg_rdata | output | 8 | Read data, one cycle after the read |

## Verification
The hardest case to reach is a clearing read that lands in the same cycle as a change event. A clock-loss pulse that coincides with a packet is a close second. Normal traffic rarely lines these up. The stimulus therefore drives every input from one per-cycle task, which can place a mirror read, a packet strobe and a clock-loss pulse in a single cycle. A reference model then predicts both the returned value and the flags that remain afterwards.

// File: rtl/pkt_status_pkg.sv
package pkt_status_pkg;
   localparam int unsigned KIND_CODE_W = 3;

   typedef enum logic [KIND_CODE_W-1:0] {
      PK_AVI   = 3'd0,
      PK_AUDIO = 3'd1,
      PK_SPD   = 3'd2,
      PK_MPEG  = 3'd3,
      PK_ACP   = 3'd4,
      PK_ISRC1 = 3'd5,
      PK_ISRC2 = 3'd6,
      PK_NONE  = 3'd7
   } pkt_kind_e;
endpackage

// File: rtl/pst_event_decode.sv
module pst_event_decode #(
   parameter int unsigned NUM_KINDS = 7,
   parameter int unsigned CODE_W    = 3
) (
   input  logic                 ev_valid,
   input  logic [CODE_W-1:0]    ev_code,
   input  logic                 ev_changed,
   output logic [NUM_KINDS-1:0] arr_set,
   output logic [NUM_KINDS-1:0] chg_set
);
   if (NUM_KINDS > (1 << CODE_W)) begin : g_bad_width
      $error("pst_event_decode: NUM_KINDS does not fit in CODE_W");
   end

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      always_comb begin
         arr_set[k] = ev_valid && (ev_code == CODE_W'(k));
         chg_set[k] = arr_set[k] && ev_changed;
      end
   end
endmodule

// File: rtl/pst_sticky_bank.sv
module pst_sticky_bank #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic [WIDTH-1:0] set_vec,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("pst_sticky_bank: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          q[b] <= 1'b0;
         else if (set_vec[b]) q[b] <= 1'b1;
         else if (clr_all)    q[b] <= 1'b0;
      end

      // R3: a set bit holds unless cleared
      p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (q[b] && !clr_all) |=> q[b]);
      // R5, R9: a set request wins over a clear
      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[b] |=> q[b]);
   end
endmodule

// File: rtl/pst_addr_map.sv
module pst_addr_map #(
   parameter int unsigned          ADDR_W     = 8,
   parameter logic [ADDR_W-1:0]    ARR_ADDR   = 8'h5A,
   parameter int unsigned          MIRROR_LSB = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_arr,
   output logic              hit_chg
);
   if (MIRROR_LSB >= ADDR_W) begin : g_bad_mirror
      $error("pst_addr_map: MIRROR_LSB must be below ADDR_W");
   end
   if (ARR_ADDR[ADDR_W-1] && (&ARR_ADDR[MIRROR_LSB-1:0])) begin : g_overlap
      $error("pst_addr_map: arrival address collides with a change mirror");
   end

   always_comb begin
      hit_arr = (addr == ARR_ADDR);
      hit_chg = addr[ADDR_W-1] && (&addr[MIRROR_LSB-1:0]);
   end
endmodule

// File: rtl/pkt_status_regs.sv
module pkt_status_regs
   import pkt_status_pkg::*;
#(
   parameter int unsigned       NUM_KINDS  = 7,
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] ARR_ADDR   = 8'h5A,
   parameter int unsigned       MIRROR_LSB = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pkt_valid,
   input  logic [KIND_CODE_W-1:0] pkt_type,
   input  logic                   pkt_changed,
   input  logic                   clk_lost,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic                   reg_rd,
   input  logic                   reg_wr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [DATA_W-1:0]      reg_rdata
);
   if (NUM_KINDS >= DATA_W) begin : g_bad_kinds
      $error("pkt_status_regs: flags must leave the top data bit spare");
   end

   logic [NUM_KINDS-1:0] arr_set, chg_set, arr_q, chg_q;
   logic                 hit_arr, hit_chg, chg_clr;
   logic [DATA_W-1:0]    rdata_d;
   logic                 unused_wr_path;

   assign unused_wr_path = ^{reg_wr, reg_wdata};

   pst_event_decode #(.NUM_KINDS(NUM_KINDS), .CODE_W(KIND_CODE_W)) u_dec (
      .ev_valid(pkt_valid), .ev_code(pkt_type), .ev_changed(pkt_changed),
      .arr_set(arr_set), .chg_set(chg_set));

   pst_addr_map #(.ADDR_W(ADDR_W), .ARR_ADDR(ARR_ADDR), .MIRROR_LSB(MIRROR_LSB)) u_map (
      .addr(reg_addr), .hit_arr(hit_arr), .hit_chg(hit_chg));

   assign chg_clr = reg_rd && hit_chg;

   pst_sticky_bank #(.WIDTH(NUM_KINDS)) u_arr (
      .clk(clk), .rst_n(rst_n), .clr_all(clk_lost), .set_vec(arr_set), .q(arr_q));

   pst_sticky_bank #(.WIDTH(NUM_KINDS)) u_chg (
      .clk(clk), .rst_n(rst_n), .clr_all(chg_clr), .set_vec(chg_set), .q(chg_q));

   always_comb begin
      rdata_d = '0;
      if (reg_rd && hit_arr)      rdata_d = DATA_W'(arr_q);
      else if (reg_rd && hit_chg) rdata_d = DATA_W'(chg_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) reg_rdata <= '0;
      else        reg_rdata <= rdata_d;
   end

   p_mirror_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && hit_chg && !pkt_valid) |=> (chg_q == '0));
   p_read_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && hit_chg) |=> (reg_rdata == DATA_W'($past(chg_q))));
   p_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rd && !pkt_valid && !clk_lost) |=> ($stable(arr_q) && $stable(chg_q)));
   p_lost_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_lost && !pkt_valid) |=> ((arr_q == '0) && $stable(chg_q)));
   p_no_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0));
endmodule

// File: tb/pkt_status_regs_bench.sv
module pkt_status_regs_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_valid = 1'b0, pkt_changed = 1'b0, clk_lost = 1'b0;
   logic [2:0] pkt_type = '0;
   logic [7:0] reg_addr = '0, reg_wdata = '0;
   logic       reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_rdata;

   int total = 0, bad = 0;
   logic [7:0] m_arr = '0, m_chg = '0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_status_regs u_pkt_status_regs (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_type(pkt_type),
      .pkt_changed(pkt_changed), .clk_lost(clk_lost), .reg_addr(reg_addr),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   // monitor: result appears one cycle after the read strobe
   always @(posedge clk) begin
      if (rst_n && reg_rd) begin
         #1;
         if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (reg_rdata !== e) begin
               bad++;
               $display("FAIL %s: rdata=%02h expected=%02h", t, reg_rdata, e);
            end
         end
      end else if (rst_n) begin
         #1;
         total++;
         if (reg_rdata !== 8'h00) begin
            bad++;
            $display("FAIL R6 idle: rdata=%02h expected=00", reg_rdata);
         end
      end
   end

   // one cycle of stimulus; the model predicts the read value and the next state
   task automatic cyc(input string tag, input bit pv, input int pt, input bit pc,
                      input bit lost, input bit rd, input bit wr, input int addr);
      logic [7:0] ev, cv, rv;
      bit mir;
      @(negedge clk);
      pkt_valid = pv; pkt_type = 3'(pt); pkt_changed = pc; clk_lost = lost;
      reg_rd = rd; reg_wr = wr; reg_addr = 8'(addr); reg_wdata = 8'h5A;
      mir = addr[7] && (addr[2:0] == 3'b111);
      ev = (pv && pt < 7) ? (8'h01 << pt) : 8'h00;
      cv = pc ? ev : 8'h00;
      rv = 8'h00;
      if (rd && addr == 8'h5A) rv = m_arr;
      else if (rd && mir)      rv = m_chg;
      if (rd) begin exp_q.push_back(rv); tag_q.push_back(tag); end
      if (lost) m_arr = 8'h00;
      m_arr |= ev;
      if (rd && mir) m_chg = 8'h00;
      m_chg |= cv;
   endtask

   task automatic idle();
      cyc("R6", 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic rd(input string tag, input int addr);
      cyc(tag, 0, 0, 0, 0, 1, 0, addr);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pkt_valid = 0; clk_lost = 0; reg_rd = 0; reg_wr = 0;
      m_arr = '0; m_chg = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      rd("R1 arrival after reset", 8'h5A);
      rd("R1 change after reset", 8'h87);
      cyc("R5 arrival only", 1, 0, 0, 0, 0, 0, 0);
      rd("R5 arrival bit0", 8'h5A);
      rd("R5 no change flag", 8'h87);
      for (int k = 1; k < 7; k++) cyc("R2", 1, k, 1, 0, 0, 0, 0);
      cyc("R2 code 7 ignored", 1, 7, 1, 0, 0, 0, 0);
      rd("R2 all kinds arrived", 8'h5A);
      rd("R3 arrival stays set", 8'h5A);
      rd("R7 mirror 0x8F", 8'h8F);
      rd("R8 cleared after mirror read", 8'hFF);
      rd("R8 arrival untouched by mirror read", 8'h5A);
      cyc("R10", 0, 0, 0, 0, 0, 1, 8'h5A);
      cyc("R10", 0, 0, 0, 0, 0, 1, 8'hB7);
      rd("R10 arrival unchanged by write", 8'h5A);
      rd("R10 change unchanged by write", 8'hB7);
      cyc("R5 changed", 1, 4, 1, 0, 0, 0, 0);
      rd("R7 mirror 0xC7", 8'hC7);
      rd("R11 low-half 0x07", 8'h07);
      rd("R11 address 0x88", 8'h88);
      cyc("R4", 1, 2, 1, 0, 0, 0, 0);
      cyc("R4 lost only", 0, 0, 0, 1, 0, 0, 0);
      rd("R4 arrival cleared by clk_lost", 8'h5A);
      rd("R4 change kept through clk_lost", 8'h9F);
      cyc("R4", 1, 2, 1, 0, 0, 0, 0);
      cyc("R4 lost with packet", 1, 3, 1, 1, 0, 0, 0);
      rd("R4 packet bit survives clk_lost", 8'h5A);
      cyc("R9 collide", 1, 5, 1, 0, 1, 0, 8'h97);
      rd("R9 new event bit kept", 8'hA7);
      cyc("R9 collide same bit", 1, 6, 1, 0, 1, 0, 8'hEF);
      rd("R9 same-bit event kept", 8'hEF);
      idle();
      cyc("R6", 1, 0, 1, 0, 0, 0, 0);
      do_reset();
      idle();
      rd("R1 arrival after second reset", 8'h5A);
      rd("R1 change after second reset", 8'hF7);
      idle(); idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule